// File: doc/BRIEF.md
# Dual Twisted-Ring State Sequencer

This block is the central control sequencer of a memory-management unit that sits between a processor bus and the system bus. Its state is held as a pair: a 2-bit major part with four values and a 4-bit minor part with eight values. Both parts are twisted (Johnson) rings, so each step changes exactly one bit. The minor code walks 0, 1, 3, 7, 15, 14, 12, 8 in one direction and the reverse in the other. The major code walks 0, 1, 3, 2.

Surrounding control logic asks for a step with four request lines: forward or backward on the major ring, and forward or backward on the minor ring. Each ring moves by at most one position per clock. The pair is decoded into one line per combined state, in both polarities, and into one line per major value. Two combinations of the pair, 2.8 and 2.12, are not valid states. They light no state line and they raise a sticky error flag. If both directions are asked of the same ring in one clock, that ring holds and its conflict output pulses.

Top module: `mmu_seq_top`

## Requirements
- R1: After reset the state is 0.0: `major_o`=0, `minor_o`=0, only `state_hot_o[0]` is high, `illegal_o`=0, and both conflict outputs are 0.
- R2: A major forward request alone moves `major_o` one place along 0→1→3→2→0 at the next clock edge.
- R3: A major backward request alone moves `major_o` one place along 0→2→3→1→0 at the next clock edge.
- R4: A minor forward request alone moves `minor_o` one place along 0→1→3→7→15→14→12→8→0 at the next clock edge.
- R5: A minor backward request alone moves `minor_o` one place along 0→8→12→14→15→7→3→1→0 at the next clock edge.
- R6: The two rings step independently in the same clock. A ring with no request holds its value.
- R7: When forward and backward are both requested for one ring, that ring holds. Its conflict output is 1 for exactly the following cycle. The other ring is not affected.
- R8: For a valid state, exactly one bit of `state_hot_o` is high, at index major×8 + p, where p is the minor ring position (codes 0,1,3,7,15,14,12,8 give p = 0..7). `state_hot_no` is the bitwise complement of `state_hot_o`.
- R9: `major_hot_o` has exactly one bit high, at index `major_o`.
- R10: States 2.8 and 2.12 light no bit of `state_hot_o`. `illegal_o` goes high in the same cycle such a state is entered and stays high until reset, even after the state is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| maj_fwd_i | input | 1 | Step the major ring forward |
| maj_bwd_i | input | 1 | Step the major ring backward |
| min_fwd_i | input | 1 | Step the minor ring forward |
| min_bwd_i | input | 1 | Step the minor ring backward |
| major_o | output | 2 | Major ring code |
| minor_o | output | 4 | Minor ring code |
| major_hot_o | output | 4 | One line per major code |
| state_hot_o | output | 32 | One line per combined state, active high |
| state_hot_no | output | 32 | One line per combined state, active low |
| illegal_o | output | 1 | Sticky flag for a non-existent state |
| maj_conflict_o | output | 1 | Pulse after opposing major requests |
| min_conflict_o | output | 1 | Pulse after opposing minor requests |

## Verification
Step requests are taken at a rising edge. The ring codes and both conflict pulses change at that same edge, so they are due one cycle after the request. The decoded lines and `illegal_o` are combinational from the ring codes, so they change together with the codes. The bench drives requests on the falling edge and samples every output 1 ns after the next rising edge. It checks the whole output set against a position model after each step, including the idle steps that follow, so a held ring or a single-cycle conflict pulse is seen at the cycle where it is due.

// File: rtl/mmu_seq_pkg.sv
package mmu_seq_pkg;
  localparam int MAJ_W   = 2;
  localparam int MIN_W   = 4;
  localparam int MAJ_N   = 2 * MAJ_W;
  localparam int MIN_N   = 2 * MIN_W;
  localparam int MIN_PW  = $clog2(MIN_N);
  localparam int STATE_N = MAJ_N * MIN_N;
  // non-existent combinations: this major code with minor position >= GAP_POS_LO
  localparam int GAP_MAJ    = 2;
  localparam int GAP_POS_LO = 6;

  typedef logic [MAJ_W-1:0]   maj_code_t;
  typedef logic [MIN_W-1:0]   min_code_t;
  typedef logic [MIN_PW-1:0]  min_pos_t;
  typedef logic [STATE_N-1:0] state_vec_t;
endpackage

// File: rtl/seq_ring.sv
module seq_ring #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fwd_i,
  input  logic         bwd_i,
  output logic [W-1:0] code_o,
  output logic         conflict_o
);
  logic [W-1:0] code_q, code_d;
  logic         clash;
  logic         conflict_q;

  assign clash = fwd_i & bwd_i;

  always_comb begin
    code_d = code_q;
    if (fwd_i && !bwd_i)      code_d = {code_q[W-2:0], ~code_q[W-1]};
    else if (bwd_i && !fwd_i) code_d = {~code_q[0], code_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= '0;
      conflict_q <= 1'b0;
    end else begin
      code_q     <= code_d;
      conflict_q <= clash;
    end
  end

  assign code_o     = code_q;
  assign conflict_o = conflict_q;

  // R2 R4: every ring move touches at most one bit
  p_one_bit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(code_o ^ $past(code_o)) <= 1);
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_i && !bwd_i) |=> $stable(code_o));
  p_clash_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> $stable(code_o));
  p_clash_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> conflict_o);
  p_no_clash_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clash |=> !conflict_o);
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import mmu_seq_pkg::*;
(
  input  maj_code_t        maj_i,
  input  min_code_t        min_i,
  output state_vec_t       state_hot_o,
  output logic [MAJ_N-1:0] maj_hot_o,
  output logic             exists_o
);
  int        ones;
  int        pos_i;
  min_pos_t  pos;
  min_code_t regen;
  logic      valid;
  int        idx;

  // ring position from a twisted-ring code
  always_comb begin
    ones = 0;
    for (int b = 0; b < MIN_W; b++) ones += int'(min_i[b]);
    pos_i = min_i[MIN_W-1] ? (MIN_N - ones) % MIN_N : ones;
    if (min_i == '0) pos_i = 0;
    pos = min_pos_t'(pos_i);
    for (int b = 0; b < MIN_W; b++)
      regen[b] = (pos_i > b) && (pos_i <= b + MIN_W);
    valid    = (regen == min_i);
    exists_o = valid && !((int'(maj_i) == GAP_MAJ) && (pos_i >= GAP_POS_LO));
    idx      = int'(maj_i) * MIN_N + int'(pos);
  end

  for (genvar s = 0; s < STATE_N; s++) begin : g_state
    assign state_hot_o[s] = exists_o && (idx == s);
  end

  for (genvar m = 0; m < MAJ_N; m++) begin : g_major
    assign maj_hot_o[m] = (int'(maj_i) == m);
  end
endmodule

// File: rtl/mmu_seq_top.sv
module mmu_seq_top
  import mmu_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               maj_fwd_i,
  input  logic               maj_bwd_i,
  input  logic               min_fwd_i,
  input  logic               min_bwd_i,
  output logic [MAJ_W-1:0]   major_o,
  output logic [MIN_W-1:0]   minor_o,
  output logic [MAJ_N-1:0]   major_hot_o,
  output logic [STATE_N-1:0] state_hot_o,
  output logic [STATE_N-1:0] state_hot_no,
  output logic               illegal_o,
  output logic               maj_conflict_o,
  output logic               min_conflict_o
);
  maj_code_t  maj_code;
  min_code_t  min_code;
  state_vec_t hot;
  logic       exists;
  logic       illegal_q;

  seq_ring #(.W(MAJ_W)) u_maj_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .fwd_i(maj_fwd_i), .bwd_i(maj_bwd_i),
    .code_o(maj_code), .conflict_o(maj_conflict_o)
  );

  seq_ring #(.W(MIN_W)) u_min_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .fwd_i(min_fwd_i), .bwd_i(min_bwd_i),
    .code_o(min_code), .conflict_o(min_conflict_o)
  );

  seq_decode u_decode (
    .maj_i(maj_code), .min_i(min_code),
    .state_hot_o(hot), .maj_hot_o(major_hot_o), .exists_o(exists)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= illegal_q | ~exists;
  end

  assign major_o      = maj_code;
  assign minor_o      = min_code;
  assign state_hot_o  = hot;
  assign state_hot_no = ~hot;
  assign illegal_o    = illegal_q | ~exists;

  p_hot_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_hot_o));
  p_hot_present_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !illegal_o |-> ($countones(state_hot_o) == 1));
  p_major_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(major_hot_o) == 1);
  p_gap_dark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (major_o == 2'd2 && (minor_o == 4'd8 || minor_o == 4'd12))
      |-> (illegal_o && state_hot_o == '0));
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o);
endmodule

// File: tb/mmu_seq_top_tb_top.sv
`timescale 1ns/1ps
module mmu_seq_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        maj_fwd_i = 1'b0, maj_bwd_i = 1'b0, min_fwd_i = 1'b0, min_bwd_i = 1'b0;
  logic [1:0]  major_o;
  logic [3:0]  minor_o;
  logic [3:0]  major_hot_o;
  logic [31:0] state_hot_o, state_hot_no;
  logic        illegal_o, maj_conflict_o, min_conflict_o;

  int n_cmp = 0;
  int n_bad = 0;

  // model
  int   m_maj_pos = 0;
  int   m_min_pos = 0;
  logic m_ill = 1'b0;
  logic m_mc = 1'b0, m_nc = 1'b0;

  always #5 clk_i = ~clk_i;

  mmu_seq_top dut_i (.*);

  function automatic int maj_of(int p);
    case (p)
      0: return 0; 1: return 1; 2: return 3; default: return 2;
    endcase
  endfunction

  function automatic int min_of(int p);
    case (p)
      0: return 0;  1: return 1;  2: return 3;  3: return 7;
      4: return 15; 5: return 14; 6: return 12; default: return 8;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    int mj = maj_of(m_maj_pos);
    int mn = min_of(m_min_pos);
    logic gap = (mj == 2) && (m_min_pos >= 6);
    logic [31:0] hot = gap ? 32'h0 : (32'h1 << (mj * 8 + m_min_pos));
    if (gap) m_ill = 1'b1;
    chk(req, "major_o", 32'(major_o), 32'(mj));
    chk(req, "minor_o", 32'(minor_o), 32'(mn));
    chk("R8", "state_hot_o", state_hot_o, hot);
    chk("R8", "state_hot_no", state_hot_no, ~hot);
    chk("R9", "major_hot_o", 32'(major_hot_o), 32'h1 << mj);
    chk(req, "illegal_o", 32'(illegal_o), 32'(m_ill));
    chk(req, "maj_conflict_o", 32'(maj_conflict_o), 32'(m_mc));
    chk(req, "min_conflict_o", 32'(min_conflict_o), 32'(m_nc));
  endtask

  task automatic step(logic mf, logic mb, logic nf, logic nb, string req);
    @(negedge clk_i);
    maj_fwd_i = mf; maj_bwd_i = mb; min_fwd_i = nf; min_bwd_i = nb;
    @(posedge clk_i);
    #1;
    if (mf && !mb) m_maj_pos = (m_maj_pos + 1) % 4;
    if (mb && !mf) m_maj_pos = (m_maj_pos + 3) % 4;
    if (nf && !nb) m_min_pos = (m_min_pos + 1) % 8;
    if (nb && !nf) m_min_pos = (m_min_pos + 7) % 8;
    m_mc = mf & mb;
    m_nc = nf & nb;
    check_all(req);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    maj_fwd_i = 0; maj_bwd_i = 0; min_fwd_i = 0; min_bwd_i = 0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    m_maj_pos = 0; m_min_pos = 0; m_ill = 0; m_mc = 0; m_nc = 0;
    check_all("R1");
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check_all("R1");
  endtask

  task automatic t_major_walk();
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R3");
  endtask

  task automatic t_minor_walk();
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R4");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, "R5");
  endtask

  task automatic t_joint();
    step(1, 0, 1, 0, "R6");
    step(1, 0, 0, 1, "R6");
    step(0, 0, 0, 0, "R6");
    step(0, 1, 1, 0, "R6");
    step(0, 0, 0, 0, "R6");
  endtask

  task automatic t_conflict();
    step(1, 1, 1, 0, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 0, 1, 1, "R7");
    step(0, 0, 0, 0, "R7");
    step(1, 1, 1, 1, "R7");
    step(0, 0, 0, 0, "R7");
  endtask

  task automatic t_gap();
    t_reset();
    step(0, 1, 0, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(0, 0, 0, 1, "R10");
    step(1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");
    t_reset();
    step(0, 1, 0, 0, "R10");
    step(0, 0, 0, 1, "R10");
  endtask

  initial begin
    t_reset();
    t_major_walk();
    t_minor_walk();
    t_joint();
    t_conflict();
    t_gap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule